// File: doc/BRIEF.md
# Configurable Logic Cell with Pin Driver

This block is one storage-and-output cell of a programmable logic block. It receives the sum-of-products result computed for it elsewhere and turns it into a cell value. Depending on its configuration, that value comes straight from the logic, from an edge-triggered D or toggle register, or from a latch that is open while its gate is low. The cell value returns to the logic array as feedback. It also drives a pin through a polarity inverter and a tri-state enable. A cell with no pin of its own can capture the pin level instead, through the same register or latch, and so act as an input synchroniser.

The cell runs on one system clock `clk`. The two gate lines are level signals sampled on that clock. A rising edge on the selected line is a clock cycle in which that line is 1 after it was 0 at the previous sample. The storage element loads on the clock edge that sees the rise, and the new value shows on `fb_out` from then on. The reset term and the preset term are shared across the block and act as level overrides that take effect on the clock edge. `rst_n` is the power-up clear. A test path can preload the storage element from the pin. A second test mode, observe, makes the stored value visible on the pin.

Top module: `macro_cell`

## Requirements
- R1: With `cfg_mode`=0 (combinatorial) and observe off, `fb_out` equals the selected data in the same cycle. The selected data is `sop_in`, or `pin_in` when `cfg_buried_in`=1. No clock edge is needed.
- R2: With `cfg_mode`=1 (D register), the stored value loads the selected data only on a clock edge where the selected gate line is 1 and was 0 at the previous edge. At all other edges it holds.
- R3: With `cfg_mode`=2 (toggle register), on a rising gate edge the stored value inverts when the selected data is 1 and holds when it is 0.
- R4: With `cfg_mode`=3 (latch), the stored value follows the selected data on every clock edge at which the selected gate line is 0. It holds while that line is 1.
- R5: `pin_out` always equals `fb_out` XOR `cfg_inv`.
- R6: `ar_term`=1 clears the stored value at the next edge. `ap_term`=1 sets it to 1. When both are 1, the clear wins. Both override preload and the mode logic.
- R7: With observe off, `pin_oe` depends on `cfg_oe_mode`. Code 0 gives 0, code 1 gives 1, code 2 gives `oe_terms[cfg_oe_sel]`, and code 3 gives 0.
- R8: With `cfg_buried_in`=1, the register or latch captures `pin_in`, and `sop_in` has no effect on the cell.
- R9: While `rst_n` is 0, and right after it rises, the stored value is 0. `fb_out` reads 0 in the storage modes, and `pin_out` equals `cfg_inv`.
- R10: With `tst_preload`=1 and neither shared term active, the stored value loads `pin_in` at the next edge in every mode, with no gate edge.
- R11: With `tst_observe`=1, `pin_oe` is 1. A combinatorial cell then behaves as a D register whose data is 0, and `fb_out` shows the stored value.
- R12: `cfg_gate_sel` picks `gate_in[0]` (value 0) or `gate_in[1]` (value 1). Edges and levels on the other line have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-up clear, active low, asynchronous |
| cfg_mode | input | 2 | 0 combinatorial, 1 D register, 2 toggle register, 3 latch |
| cfg_inv | input | 1 | Pin polarity invert |
| cfg_gate_sel | input | 1 | Gate line select |
| cfg_oe_mode | input | 2 | Output enable mode (see R7) |
| cfg_oe_sel | input | 1 | Which shared enable term drives the pin in mode 2 |
| cfg_buried_in | input | 1 | Capture pin level instead of logic result |
| sop_in | input | 1 | Sum-of-products result |
| gate_in | input | 2 | Shared clock/gate lines |
| ar_term | input | 1 | Shared clear term |
| ap_term | input | 1 | Shared preset term |
| oe_terms | input | 2 | Shared output enable terms |
| tst_preload | input | 1 | Load storage from pin |
| tst_observe | input | 1 | Force enable and show stored value |
| pin_in | input | 1 | Level seen on the pin |
| pin_out | output | 1 | Value driven to the pin |
| pin_oe | output | 1 | Pin driver enable |
| fb_out | output | 1 | Internal feedback |

## Verification
The hardest situation to reach from the ports is observe on a combinatorial cell. The stored value must change only through a gate rise that loads zero, while the same cell in normal operation bypasses storage completely. The stimulus first preloads a 1 through the pin path, then enables observe. It checks that the 1 is held until a gate rise, after which it drops to 0. A behavioural model in the bench tracks the stored bit and the previous gate sample. Every output is compared with that model after each clock. This includes the stretches where only the unselected gate line toggles.

// File: rtl/macro_cell_pkg.sv
package macro_cell_pkg;

   typedef enum logic [1:0] {
      MODE_COMB  = 2'd0,
      MODE_DREG  = 2'd1,
      MODE_TREG  = 2'd2,
      MODE_LATCH = 2'd3
   } cell_mode_e;

   typedef enum logic [1:0] {
      OE_OFF  = 2'd0,
      OE_ON   = 2'd1,
      OE_TERM = 2'd2,
      OE_RSVD = 2'd3
   } oe_mode_e;

endpackage

// File: rtl/macro_gate_sel.sv
module macro_gate_sel #(
   parameter int NUM_GATES = 2,
   localparam int SEL_W = (NUM_GATES > 1) ? $clog2(NUM_GATES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_GATES-1:0] gate_in,
   input  logic [SEL_W-1:0]     sel,
   output logic                 gate_lvl,
   output logic                 gate_rise
);

   generate
      if (NUM_GATES < 2) begin : g_bad_cfg
         $error("macro_gate_sel: NUM_GATES must be at least 2");
      end
   endgenerate

   logic gate_prev;

   assign gate_lvl = gate_in[sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gate_prev <= 1'b0;
      else        gate_prev <= gate_lvl;
   end

   assign gate_rise = gate_lvl & ~gate_prev;

endmodule

// File: rtl/macro_store.sv
module macro_store
   import macro_cell_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  cell_mode_e mode,
   input  logic       data_in,
   input  logic       pin_in,
   input  logic       gate_lvl,
   input  logic       gate_rise,
   input  logic       clr_term,
   input  logic       set_term,
   input  logic       preload,
   output logic       q
);

   logic q_nx;

   always_comb begin
      q_nx = q;
      if (clr_term)      q_nx = 1'b0;
      else if (set_term) q_nx = 1'b1;
      else if (preload)  q_nx = pin_in;
      else begin
         unique case (mode)
            MODE_DREG:  if (gate_rise) q_nx = data_in;
            MODE_TREG:  if (gate_rise) q_nx = q ^ data_in;
            MODE_LATCH: if (!gate_lvl) q_nx = data_in;
            default:    q_nx = q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= q_nx;
   end

endmodule

// File: rtl/macro_iocell.sv
module macro_iocell
   import macro_cell_pkg::*;
#(
   parameter int NUM_OE = 2,
   localparam int OSEL_W = (NUM_OE > 1) ? $clog2(NUM_OE) : 1
) (
   input  logic              cell_val,
   input  logic              inv,
   input  oe_mode_e          oe_mode,
   input  logic [OSEL_W-1:0] oe_sel,
   input  logic [NUM_OE-1:0] oe_terms,
   input  logic              observe,
   output logic              pin_out,
   output logic              pin_oe
);

   generate
      if (NUM_OE < 2) begin : g_bad_cfg
         $error("macro_iocell: NUM_OE must be at least 2");
      end
   endgenerate

   logic oe_norm;

   always_comb begin
      unique case (oe_mode)
         OE_ON:   oe_norm = 1'b1;
         OE_TERM: oe_norm = oe_terms[oe_sel];
         default: oe_norm = 1'b0;
      endcase
   end

   assign pin_oe  = observe | oe_norm;
   assign pin_out = cell_val ^ inv;

endmodule

// File: rtl/macro_cell.sv
module macro_cell
   import macro_cell_pkg::*;
#(
   parameter int NUM_GATES = 2,
   parameter int NUM_OE    = 2,
   localparam int SEL_W  = (NUM_GATES > 1) ? $clog2(NUM_GATES) : 1,
   localparam int OSEL_W = (NUM_OE > 1) ? $clog2(NUM_OE) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           cfg_mode,
   input  logic                 cfg_inv,
   input  logic [SEL_W-1:0]     cfg_gate_sel,
   input  logic [1:0]           cfg_oe_mode,
   input  logic [OSEL_W-1:0]    cfg_oe_sel,
   input  logic                 cfg_buried_in,
   input  logic                 sop_in,
   input  logic [NUM_GATES-1:0] gate_in,
   input  logic                 ar_term,
   input  logic                 ap_term,
   input  logic [NUM_OE-1:0]    oe_terms,
   input  logic                 tst_preload,
   input  logic                 tst_observe,
   input  logic                 pin_in,
   output logic                 pin_out,
   output logic                 pin_oe,
   output logic                 fb_out
);

   cell_mode_e mode_cfg;
   cell_mode_e mode_eff;
   logic       force_reg;
   logic       data_raw;
   logic       data_eff;
   logic       gate_lvl;
   logic       gate_rise;
   logic       state_q;
   logic       cell_val;

   assign mode_cfg  = cell_mode_e'(cfg_mode);
   assign force_reg = tst_observe && (mode_cfg == MODE_COMB);
   assign mode_eff  = force_reg ? MODE_DREG : mode_cfg;
   assign data_raw  = cfg_buried_in ? pin_in : sop_in;
   assign data_eff  = force_reg ? 1'b0 : data_raw;
   assign cell_val  = (mode_eff == MODE_COMB) ? data_eff : state_q;
   assign fb_out    = cell_val;

   macro_gate_sel #(.NUM_GATES(NUM_GATES)) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .gate_in   (gate_in),
      .sel       (cfg_gate_sel),
      .gate_lvl  (gate_lvl),
      .gate_rise (gate_rise)
   );

   macro_store u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode_eff),
      .data_in   (data_eff),
      .pin_in    (pin_in),
      .gate_lvl  (gate_lvl),
      .gate_rise (gate_rise),
      .clr_term  (ar_term),
      .set_term  (ap_term),
      .preload   (tst_preload),
      .q         (state_q)
   );

   macro_iocell #(.NUM_OE(NUM_OE)) u_io (
      .cell_val (cell_val),
      .inv      (cfg_inv),
      .oe_mode  (oe_mode_e'(cfg_oe_mode)),
      .oe_sel   (cfg_oe_sel),
      .oe_terms (oe_terms),
      .observe  (tst_observe),
      .pin_out  (pin_out),
      .pin_oe   (pin_oe)
   );

endmodule

// File: rtl/macro_cell_chk.sv
module macro_cell_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] cfg_mode,
   input logic       cfg_buried_in,
   input logic [1:0] cfg_oe_mode,
   input logic       sop_in,
   input logic       ar_term,
   input logic       ap_term,
   input logic       tst_preload,
   input logic       tst_observe,
   input logic       gate_lvl,
   input logic       gate_rise,
   input logic       state_q,
   input logic       pin_oe,
   input logic       fb_out
);

   // R6: clear term forces zero, even with preset active
   p_clear_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ar_term |=> (state_q == 1'b0));

   // R6: preset alone forces one
   p_preset_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ap_term && !ar_term) |=> (state_q == 1'b1));

   // R11: observe always enables the pin driver
   p_observe_oe_r11: assert property (@(posedge clk) disable iff (!rst_n)
      tst_observe |-> pin_oe);

   // R7: enable mode 0 keeps the driver off outside observe
   p_oe_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_oe_mode == 2'd0 && !tst_observe) |-> !pin_oe);

   // R2: D register without a gate rise holds
   p_dreg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode == 2'd1 && !gate_rise && !ar_term && !ap_term && !tst_preload)
      |=> $stable(state_q));

   // R4: latch with gate high holds
   p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode == 2'd3 && !tst_observe && gate_lvl && !ar_term && !ap_term && !tst_preload)
      |=> $stable(state_q));

   // R1: combinatorial cell passes the logic result through
   p_comb_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode == 2'd0 && !tst_observe && !cfg_buried_in) |-> (fb_out == sop_in));

endmodule

bind macro_cell macro_cell_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_mode      (cfg_mode),
   .cfg_buried_in (cfg_buried_in),
   .cfg_oe_mode   (cfg_oe_mode),
   .sop_in        (sop_in),
   .ar_term       (ar_term),
   .ap_term       (ap_term),
   .tst_preload   (tst_preload),
   .tst_observe   (tst_observe),
   .gate_lvl      (gate_lvl),
   .gate_rise     (gate_rise),
   .state_q       (state_q),
   .pin_oe        (pin_oe),
   .fb_out        (fb_out)
);

// File: tb/macro_cell_tb.sv
module macro_cell_tb;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cfg_mode = 2'd0;
   logic       cfg_inv = 1'b0;
   logic       cfg_gate_sel = 1'b0;
   logic [1:0] cfg_oe_mode = 2'd0;
   logic       cfg_oe_sel = 1'b0;
   logic       cfg_buried_in = 1'b0;
   logic       sop_in = 1'b0;
   logic [1:0] gate_in = 2'b00;
   logic       ar_term = 1'b0;
   logic       ap_term = 1'b0;
   logic [1:0] oe_terms = 2'b00;
   logic       tst_preload = 1'b0;
   logic       tst_observe = 1'b0;
   logic       pin_in = 1'b0;
   logic       pin_out, pin_oe, fb_out;

   int total = 0;
   int bad = 0;
   bit done = 0;
   string cur_req = "R9";

   // reference model state
   bit m_q = 0;
   bit m_gprev = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   macro_cell u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_inv(cfg_inv),
      .cfg_gate_sel(cfg_gate_sel), .cfg_oe_mode(cfg_oe_mode), .cfg_oe_sel(cfg_oe_sel),
      .cfg_buried_in(cfg_buried_in), .sop_in(sop_in), .gate_in(gate_in),
      .ar_term(ar_term), .ap_term(ap_term), .oe_terms(oe_terms),
      .tst_preload(tst_preload), .tst_observe(tst_observe), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_q = 0;
         m_gprev = 0;
      end else begin
         bit g, rise, d;
         int md;
         g    = gate_in[cfg_gate_sel];
         rise = g && !m_gprev;
         d    = cfg_buried_in ? pin_in : sop_in;
         md   = cfg_mode;
         if (tst_observe && md == 0) begin
            md = 1;
            d  = 0;
         end
         if (ar_term)          m_q = 0;
         else if (ap_term)     m_q = 1;
         else if (tst_preload) m_q = pin_in;
         else if (md == 1 && rise) m_q = d;
         else if (md == 2 && rise) m_q = m_q ^ d;
         else if (md == 3 && !g)   m_q = d;
         m_gprev = g;
      end
   end

   function automatic bit exp_fb();
      if (cfg_mode == 2'd0 && !tst_observe) return cfg_buried_in ? pin_in : sop_in;
      return m_q;
   endfunction

   function automatic bit exp_oe();
      if (tst_observe) return 1;
      case (cfg_oe_mode)
         2'd1:    return 1;
         2'd2:    return oe_terms[cfg_oe_sel];
         default: return 0;
      endcase
   endfunction

   task automatic check_bit(string what, bit act, bit exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0b expected=%0b at %0t", cur_req, what, act, exp, $time);
      end
   endtask

   task automatic compare();
      check_bit("fb_out", fb_out, exp_fb());
      check_bit("pin_out", pin_out, exp_fb() ^ cfg_inv);
      check_bit("pin_oe", pin_oe, exp_oe());
   endtask

   // one clock, then compare after the edge has settled
   task automatic step();
      @(posedge clk);
      @(negedge clk);
      #1;
      compare();
   endtask

   task automatic pulse_gate(int idx);
      gate_in[idx] = 1'b1;
      step();
      gate_in[idx] = 1'b0;
      step();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
   end

   initial begin
      // R9: power-up clear, storage mode so fb shows the stored bit
      cur_req = "R9";
      cfg_mode = 2'd1;
      cfg_inv = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      compare();
      check_bit("fb_out during reset", fb_out, 1'b0);
      rst_n = 1'b1;
      step();
      check_bit("pin_out after reset", pin_out, 1'b1);

      // R1 and R5: combinatorial pass-through with both polarities
      cur_req = "R1";
      cfg_mode = 2'd0;
      cfg_oe_mode = 2'd1;
      for (int i = 0; i < 6; i++) begin
         sop_in = i[0];
         cfg_inv = i[1];
         #1 compare();
         cur_req = "R5";
         step();
         cur_req = "R1";
      end

      // R2: D register captures only on a selected rise
      cur_req = "R2";
      cfg_mode = 2'd1;
      cfg_inv = 1'b0;
      sop_in = 1'b1;
      step();
      pulse_gate(0);
      sop_in = 1'b0;
      step();
      gate_in[0] = 1'b1;
      step();
      sop_in = 1'b1;
      step();
      step();
      gate_in[0] = 1'b0;
      step();
      pulse_gate(0);

      // R12: unselected line ignored, selected line works
      cur_req = "R12";
      cfg_gate_sel = 1'b1;
      sop_in = 1'b0;
      pulse_gate(0);
      pulse_gate(0);
      pulse_gate(1);
      sop_in = 1'b1;
      gate_in[0] = 1'b1;
      step();
      gate_in[0] = 1'b0;
      step();
      pulse_gate(1);
      cfg_gate_sel = 1'b0;

      // R3: toggle register
      cur_req = "R3";
      cfg_mode = 2'd2;
      sop_in = 1'b1;
      pulse_gate(0);
      pulse_gate(0);
      pulse_gate(0);
      sop_in = 1'b0;
      pulse_gate(0);
      step();

      // R4: latch transparent low, holds high
      cur_req = "R4";
      cfg_mode = 2'd3;
      gate_in[0] = 1'b0;
      sop_in = 1'b0;
      step();
      sop_in = 1'b1;
      step();
      gate_in[0] = 1'b1;
      step();
      sop_in = 1'b0;
      step();
      step();
      gate_in[0] = 1'b0;
      step();

      // R6: shared clear and preset, clear wins
      cur_req = "R6";
      cfg_mode = 2'd1;
      ap_term = 1'b1;
      step();
      check_bit("preset", fb_out, 1'b1);
      ar_term = 1'b1;
      step();
      check_bit("clear over preset", fb_out, 1'b0);
      ar_term = 1'b0;
      step();
      ap_term = 1'b0;
      tst_preload = 1'b0;
      ar_term = 1'b1;
      sop_in = 1'b1;
      pulse_gate(0);
      ar_term = 1'b0;
      step();

      // R7: every enable mode and term selection
      cur_req = "R7";
      for (int m = 0; m < 4; m++) begin
         for (int t = 0; t < 8; t++) begin
            cfg_oe_mode = m[1:0];
            cfg_oe_sel  = t[2];
            oe_terms    = t[1:0];
            #1 compare();
         end
      end
      cfg_oe_mode = 2'd1;

      // R8: buried input capture ignores sop_in
      cur_req = "R8";
      cfg_buried_in = 1'b1;
      cfg_mode = 2'd1;
      sop_in = 1'b0;
      pin_in = 1'b1;
      pulse_gate(0);
      check_bit("captured pin", fb_out, 1'b1);
      sop_in = 1'b1;
      pin_in = 1'b0;
      pulse_gate(0);
      check_bit("captured pin low", fb_out, 1'b0);
      cfg_mode = 2'd3;
      pin_in = 1'b1;
      step();
      cfg_buried_in = 1'b0;

      // R10: preload from the pin without any gate activity
      cur_req = "R10";
      for (int m = 1; m < 4; m++) begin
         cfg_mode = m[1:0];
         gate_in[0] = 1'b1;
         step();
         tst_preload = 1'b1;
         pin_in = m[0];
         step();
         tst_preload = 1'b0;
         step();
         gate_in[0] = 1'b0;
         step();
      end

      // R11: observe on a combinatorial cell
      cur_req = "R11";
      cfg_mode = 2'd1;
      tst_preload = 1'b1;
      pin_in = 1'b1;
      step();
      tst_preload = 1'b0;
      cfg_mode = 2'd0;
      cfg_oe_mode = 2'd0;
      sop_in = 1'b1;
      tst_observe = 1'b1;
      step();
      check_bit("observe holds stored 1", fb_out, 1'b1);
      check_bit("observe enables pin", pin_oe, 1'b1);
      pulse_gate(0);
      check_bit("observe loads zero", fb_out, 1'b0);
      tst_observe = 1'b0;
      step();

      finish_run();
   end

endmodule